// File: doc/BRIEF.md
# Load-Store Dependence Matrix

This block decides when a load that was issued ahead of older stores stops being speculative. It keeps one bit per pair of load-queue slot and store-queue slot. A set bit means the load still waits on that store's address. Load slots are handed out in any order and return in any order. The store queue is a first-in first-out ring, because stores retire in program order. No position or timestamp comparison is involved: the bits alone record which stores each load waits on.

When a load issues, the scheduler hands over the set of older stores whose addresses are still unknown, and the block writes it into that load's row. A store that resolves its address selects its column with a one-hot select and ORs the selected bits. That column read finds every load still waiting on it. Each of those loads then either drops its bit (no overlap) or is squashed (overlap). The per-load overlap vector comes from address comparison outside the block.

A load whose row reduces to zero emits a single non-speculative pulse. The commit logic uses that pulse to clear the load's speculation flag and let it retire early. Freeing a load slot clears its row. Dequeuing the oldest store clears that store's column.

Top module: `ldst_dep_matrix`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both output vectors are zero. After reset the oldest-store pointer is at store slot 0, and no load counts as issued.
- R2: A load issued with an empty wait mask raises its bit of `ld_nonspec` in the cycle after the issue edge.
- R3: A load issued with a non-empty wait mask keeps its `ld_nonspec` bit low until every store in the mask has resolved without overlap. It pulses in the cycle after the last of those resolves.
- R4: A store resolve whose overlap vector has the bit of a load that still waits on that store squashes that load. `ld_squash` pulses for exactly one cycle, in the cycle after the resolve. The load's row and issued state are cleared, so the load never reports non-speculative afterwards.
- R5: Overlap bits for loads that do not wait on the resolving store (bit clear in their row, or not issued) are ignored. No squash follows and no row changes.
- R6: A load's `ld_nonspec` bit pulses at most once per issue. It stays low afterwards until the slot is issued again.
- R7: A load slot that has not issued since reset, or since it was freed or squashed, never raises `ld_nonspec`.
- R8: `sq_deq` retires the store at the oldest-store pointer. It clears that store's column and advances the pointer by one, wrapping from slot SQ_DEPTH-1 back to slot 0. Loads released by that clearing pulse `ld_nonspec` in the next cycle.
- R9: On a load issue, bits of the wait mask that name the store resolving in the same cycle, or the store dequeued in the same cycle, are dropped. The new load takes no overlap check from that same-cycle resolve.
- R10: `ld_free` clears a load's row and issued state. A later issue of the same slot yields a fresh non-speculative pulse.
- R11: Several loads may turn non-speculative in the same cycle. Each one's bit pulses together in `ld_nonspec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_issue_valid | input | 1 | A load issues this cycle |
| ld_issue_idx | input | $clog2(LQ_DEPTH) | Load-queue slot of the issuing load |
| ld_issue_mask | input | SQ_DEPTH | Older stores with unresolved addresses (bit n = store slot n) |
| st_res_valid | input | 1 | A store resolves its address this cycle |
| st_res_idx | input | $clog2(SQ_DEPTH) | Store-queue slot of the resolving store |
| st_res_conflict | input | LQ_DEPTH | Per-load overlap with the resolving store (bit n = load slot n) |
| ld_free_valid | input | 1 | A load slot is released |
| ld_free_idx | input | $clog2(LQ_DEPTH) | Released load slot |
| sq_deq | input | 1 | The oldest store leaves the store queue |
| ld_nonspec | output | LQ_DEPTH | One-cycle pulse per load that became non-speculative |
| ld_squash | output | LQ_DEPTH | One-cycle pulse per load squashed by an overlap |

## Verification
A stale bit left in a row shows up as a missing `ld_nonspec` pulse, one cycle after the resolve or dequeue that should have cleared it. A bit wrongly cleared shows up as an early pulse in that same cycle. A wrong oldest-store pointer releases the wrong loads at the dequeue that follows, which is visible one cycle later. A lost announced flag shows as a repeated pulse in the very next cycle. Squash errors show as `ld_squash` pulses that do not match the overlap vector, or as a non-speculative pulse from a load that was squashed.

// File: rtl/ldst_dep_pkg.sv
package ldst_dep_pkg;

  // per-slot control decoded at the top and handed to one load entry
  typedef struct packed {
    logic issue;
    logic free;
    logic conflict;
  } entry_ctl_t;

endpackage

// File: rtl/ldst_sq_head.sv
module ldst_sq_head #(
  parameter int SQ_DEPTH = 4,
  localparam int SIW = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                deq,
  output logic [SQ_DEPTH-1:0] deq_col
);

  logic [SIW-1:0] head_q;
  logic [SIW-1:0] head_d;

  always_comb begin
    head_d = head_q;
    if (deq) begin
      if (head_q == SIW'(SQ_DEPTH - 1)) head_d = '0;
      else                              head_d = head_q + SIW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   head_q <= '0;
    else if (deq) head_q <= head_d;
  end

  // one-hot column select for the store leaving the queue this cycle
  for (genvar s = 0; s < SQ_DEPTH; s++) begin : g_col
    assign deq_col[s] = deq && (head_q == SIW'(s));
  end

endmodule

// File: rtl/ldst_dep_entry.sv
module ldst_dep_entry
  import ldst_dep_pkg::*;
#(
  parameter int SQ_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  entry_ctl_t          ctl,
  input  logic [SQ_DEPTH-1:0] issue_mask,
  input  logic [SQ_DEPTH-1:0] res_col,
  input  logic [SQ_DEPTH-1:0] deq_col,
  output logic                dep_hit,
  output logic                nonspec,
  output logic                squash
);

  logic [SQ_DEPTH-1:0] row_q, row_d;
  logic                issued_q, issued_d;
  logic                told_q, told_d;
  logic                squash_q, squash_d;
  logic                squash_now;
  logic                row_en;
  logic [SQ_DEPTH-1:0] drop_cols;

  // column read: AND with the one-hot resolve select, then OR-reduce
  assign dep_hit    = |(row_q & res_col);
  assign squash_now = dep_hit && ctl.conflict && !ctl.issue;
  assign drop_cols  = res_col | deq_col;

  assign row_en = ctl.issue | ctl.free | (|drop_cols);

  always_comb begin
    row_d    = row_q;
    issued_d = issued_q;
    told_d   = told_q;
    if (ctl.issue) begin
      row_d    = issue_mask & ~drop_cols;
      issued_d = 1'b1;
      told_d   = 1'b0;
    end else if (ctl.free || squash_now) begin
      row_d    = '0;
      issued_d = 1'b0;
      told_d   = 1'b0;
    end else begin
      row_d  = row_q & ~drop_cols;
      told_d = told_q | nonspec;
    end
    squash_d = squash_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (row_en) row_q <= row_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issued_q <= 1'b0;
      told_q   <= 1'b0;
      squash_q <= 1'b0;
    end else begin
      issued_q <= issued_d;
      told_q   <= told_d;
      squash_q <= squash_d;
    end
  end

  assign nonspec = issued_q && !(|row_q) && !told_q;
  assign squash  = squash_q;

endmodule

// File: rtl/ldst_dep_matrix.sv
module ldst_dep_matrix
  import ldst_dep_pkg::*;
#(
  parameter int LQ_DEPTH = 8,
  parameter int SQ_DEPTH = 4,
  localparam int LIW = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1,
  localparam int SIW = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_issue_valid,
  input  logic [LIW-1:0]      ld_issue_idx,
  input  logic [SQ_DEPTH-1:0] ld_issue_mask,
  input  logic                st_res_valid,
  input  logic [SIW-1:0]      st_res_idx,
  input  logic [LQ_DEPTH-1:0] st_res_conflict,
  input  logic                ld_free_valid,
  input  logic [LIW-1:0]      ld_free_idx,
  input  logic                sq_deq,
  output logic [LQ_DEPTH-1:0] ld_nonspec,
  output logic [LQ_DEPTH-1:0] ld_squash
);

  logic [SQ_DEPTH-1:0] res_col;
  logic [SQ_DEPTH-1:0] deq_col;
  logic [LQ_DEPTH-1:0] dep_hit;

  for (genvar s = 0; s < SQ_DEPTH; s++) begin : g_res
    assign res_col[s] = st_res_valid && (st_res_idx == SIW'(s));
  end

  ldst_sq_head #(.SQ_DEPTH(SQ_DEPTH)) u_head (
    .clk     (clk),
    .rst_n   (rst_n),
    .deq     (sq_deq),
    .deq_col (deq_col)
  );

  for (genvar l = 0; l < LQ_DEPTH; l++) begin : g_ld
    entry_ctl_t ctl;
    assign ctl.issue    = ld_issue_valid && (ld_issue_idx == LIW'(l));
    assign ctl.free     = ld_free_valid && (ld_free_idx == LIW'(l));
    assign ctl.conflict = st_res_conflict[l];

    ldst_dep_entry #(.SQ_DEPTH(SQ_DEPTH)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl        (ctl),
      .issue_mask (ld_issue_mask),
      .res_col    (res_col),
      .deq_col    (deq_col),
      .dep_hit    (dep_hit[l]),
      .nonspec    (ld_nonspec[l]),
      .squash     (ld_squash[l])
    );
  end

endmodule

// File: rtl/ldst_dep_matrix_chk.sv
module ldst_dep_matrix_chk #(
  parameter int LQ_DEPTH = 8,
  parameter int SQ_DEPTH = 4,
  localparam int LIW = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1,
  localparam int SIW = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ld_issue_valid,
  input logic [LIW-1:0]      ld_issue_idx,
  input logic [SQ_DEPTH-1:0] ld_issue_mask,
  input logic                st_res_valid,
  input logic [SIW-1:0]      st_res_idx,
  input logic [LQ_DEPTH-1:0] st_res_conflict,
  input logic                ld_free_valid,
  input logic [LIW-1:0]      ld_free_idx,
  input logic                sq_deq,
  input logic [LQ_DEPTH-1:0] ld_nonspec,
  input logic [LQ_DEPTH-1:0] ld_squash
);

  // R2
  empty_mask_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_issue_valid && ld_issue_mask == '0) |=> ld_nonspec[$past(ld_issue_idx)]);

  // R4
  squash_after_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ld_squash) |-> $past(st_res_valid));

  // R4
  squash_excludes_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_squash & ld_nonspec) == '0);

  // R5
  squash_needs_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ld_squash) |-> ((ld_squash & ~$past(st_res_conflict)) == '0));

  // R6
  for (genvar l = 0; l < LQ_DEPTH; l++) begin : g_once
    single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_nonspec[l] && !(ld_issue_valid && ld_issue_idx == LIW'(l)))
        |=> !ld_nonspec[l]);
  end

endmodule

bind ldst_dep_matrix ldst_dep_matrix_chk #(
  .LQ_DEPTH(LQ_DEPTH),
  .SQ_DEPTH(SQ_DEPTH)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ld_issue_valid  (ld_issue_valid),
  .ld_issue_idx    (ld_issue_idx),
  .ld_issue_mask   (ld_issue_mask),
  .st_res_valid    (st_res_valid),
  .st_res_idx      (st_res_idx),
  .st_res_conflict (st_res_conflict),
  .ld_free_valid   (ld_free_valid),
  .ld_free_idx     (ld_free_idx),
  .sq_deq          (sq_deq),
  .ld_nonspec      (ld_nonspec),
  .ld_squash       (ld_squash)
);

// File: tb/sim_ldst_dep_matrix.sv
module sim_ldst_dep_matrix;

  localparam int PERIOD = 10;
  localparam int L = 8;
  localparam int S = 4;

  logic         clk;
  logic         rst_n;
  logic         ld_issue_valid;
  logic [2:0]   ld_issue_idx;
  logic [S-1:0] ld_issue_mask;
  logic         st_res_valid;
  logic [1:0]   st_res_idx;
  logic [L-1:0] st_res_conflict;
  logic         ld_free_valid;
  logic [2:0]   ld_free_idx;
  logic         sq_deq;
  logic [L-1:0] ld_nonspec;
  logic [L-1:0] ld_squash;

  int total;
  int bad;
  bit done;

  ldst_dep_matrix #(.LQ_DEPTH(L), .SQ_DEPTH(S)) u0 (.*);

  typedef struct packed {
    logic       iv;
    logic [2:0] ii;
    logic [3:0] im;
    logic       rv;
    logic [1:0] ri;
    logic [7:0] rc;
    logic       fv;
    logic [2:0] fi;
    logic       dq;
    logic [7:0] ens;
    logic [7:0] esq;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    // iv ii   im       rv ri   rc            fv fi   dq  ens           esq           req
    '{1'b0,3'd0,4'b0000,1'b0,2'd0,8'h00,1'b0,3'd0,1'b0,8'h00,8'h00,4'd7},  // R7 idle
    '{1'b1,3'd0,4'b0000,1'b0,2'd0,8'h00,1'b0,3'd0,1'b0,8'h01,8'h00,4'd2},  // R2
    '{1'b0,3'd0,4'b0000,1'b0,2'd0,8'h00,1'b0,3'd0,1'b0,8'h00,8'h00,4'd6},  // R6
    '{1'b1,3'd1,4'b0011,1'b0,2'd0,8'h00,1'b0,3'd0,1'b0,8'h00,8'h00,4'd3},  // R3
    '{1'b1,3'd2,4'b0010,1'b0,2'd0,8'h00,1'b0,3'd0,1'b0,8'h00,8'h00,4'd3},  // R3
    '{1'b0,3'd0,4'b0000,1'b1,2'd0,8'h05,1'b0,3'd0,1'b0,8'h00,8'h00,4'd5},  // R5 ld0/ld2 not waiting on st0
    '{1'b0,3'd0,4'b0000,1'b1,2'd1,8'h04,1'b0,3'd0,1'b0,8'h02,8'h04,4'd4},  // R4 squash ld2, R3 release ld1
    '{1'b0,3'd0,4'b0000,1'b0,2'd0,8'h00,1'b0,3'd0,1'b0,8'h00,8'h00,4'd4},  // R4 one-cycle squash
    '{1'b1,3'd3,4'b0100,1'b1,2'd2,8'h08,1'b0,3'd0,1'b0,8'h08,8'h00,4'd9},  // R9 same-cycle resolve
    '{1'b1,3'd4,4'b1000,1'b0,2'd0,8'h00,1'b0,3'd0,1'b0,8'h00,8'h00,4'd11},
    '{1'b1,3'd5,4'b1000,1'b0,2'd0,8'h00,1'b0,3'd0,1'b0,8'h00,8'h00,4'd11},
    '{1'b0,3'd0,4'b0000,1'b1,2'd3,8'h00,1'b0,3'd0,1'b0,8'h30,8'h00,4'd11}, // R11 two at once
    '{1'b0,3'd0,4'b0000,1'b0,2'd0,8'h00,1'b1,3'd0,1'b0,8'h00,8'h00,4'd10}, // R10 free
    '{1'b1,3'd0,4'b0000,1'b0,2'd0,8'h00,1'b0,3'd0,1'b0,8'h01,8'h00,4'd10}, // R10 fresh pulse
    '{1'b1,3'd6,4'b0001,1'b0,2'd0,8'h00,1'b0,3'd0,1'b0,8'h00,8'h00,4'd8},
    '{1'b0,3'd0,4'b0000,1'b0,2'd0,8'h00,1'b0,3'd0,1'b1,8'h40,8'h00,4'd8},  // R8 head 0
    '{1'b1,3'd7,4'b0010,1'b0,2'd0,8'h00,1'b0,3'd0,1'b0,8'h00,8'h00,4'd8},
    '{1'b0,3'd0,4'b0000,1'b0,2'd0,8'h00,1'b0,3'd0,1'b1,8'h80,8'h00,4'd8},  // R8 head 1
    '{1'b1,3'd2,4'b0001,1'b0,2'd0,8'h00,1'b0,3'd0,1'b0,8'h00,8'h00,4'd8},
    '{1'b0,3'd0,4'b0000,1'b0,2'd0,8'h00,1'b0,3'd0,1'b1,8'h00,8'h00,4'd8},  // R8 head 2
    '{1'b0,3'd0,4'b0000,1'b0,2'd0,8'h00,1'b0,3'd0,1'b1,8'h00,8'h00,4'd8},  // R8 head 3
    '{1'b0,3'd0,4'b0000,1'b0,2'd0,8'h00,1'b0,3'd0,1'b1,8'h04,8'h00,4'd8}   // R8 wrap to 0
  };

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input logic [7:0] ens, input logic [7:0] esq, input int req);
    total++;
    if (ld_nonspec !== ens || ld_squash !== esq) begin
      bad++;
      $display("FAIL R%0d: nonspec=%h squash=%h expected nonspec=%h squash=%h",
               req, ld_nonspec, ld_squash, ens, esq);
    end
  endtask

  task automatic idle_inputs();
    ld_issue_valid  = 1'b0;
    ld_issue_idx    = '0;
    ld_issue_mask   = '0;
    st_res_valid    = 1'b0;
    st_res_idx      = '0;
    st_res_conflict = '0;
    ld_free_valid   = 1'b0;
    ld_free_idx     = '0;
    sq_deq          = 1'b0;
  endtask

  // drive at the falling edge, sample a quarter period after the rising edge
  task automatic step(input vec_t v);
    @(negedge clk);
    ld_issue_valid  = v.iv;
    ld_issue_idx    = v.ii;
    ld_issue_mask   = v.im;
    st_res_valid    = v.rv;
    st_res_idx      = v.ri;
    st_res_conflict = v.rc;
    ld_free_valid   = v.fv;
    ld_free_idx     = v.fi;
    sq_deq          = v.dq;
    @(posedge clk);
    #(PERIOD/4);
    check(v.ens, v.esq, int'(v.req));
  endtask

  function automatic vec_t mk(input logic iv, input logic [2:0] ii, input logic [3:0] im,
                              input logic rv, input logic [1:0] ri, input logic dq,
                              input logic [7:0] ens, input logic [3:0] req);
    vec_t v;
    v = '0;
    v.iv = iv; v.ii = ii; v.im = im; v.rv = rv; v.ri = ri; v.dq = dq;
    v.ens = ens; v.req = req;
    return v;
  endfunction

  initial begin
    total = 0;
    bad   = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    idle_inputs();
    repeat (2) @(posedge clk);
    #1;
    check(8'h00, 8'h00, 1);  // R1 outputs idle in reset
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) step(VECS[i]);

    // R6: released loads stay silent over further idle cycles
    step(mk(1'b0, 3'd0, 4'b0000, 1'b0, 2'd0, 1'b0, 8'h00, 4'd6));

    // R1 / R7: reset wipes a pending load, which then never releases
    step(mk(1'b1, 3'd1, 4'b0001, 1'b0, 2'd0, 1'b0, 8'h00, 4'd7));
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    #1;
    check(8'h00, 8'h00, 1);  // R1 outputs clear during reset
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(mk(1'b0, 3'd0, 4'b0000, 1'b1, 2'd0, 1'b0, 8'h00, 4'd7));  // R7
    step(mk(1'b0, 3'd0, 4'b0000, 1'b0, 2'd0, 1'b1, 8'h00, 4'd7));  // R7 dequeue releases nothing
    // R1 / R8: pointer restarted at slot 0 (dequeue above took slot 0), next is slot 1
    step(mk(1'b1, 3'd5, 4'b0011, 1'b0, 2'd0, 1'b0, 8'h00, 4'd8));
    step(mk(1'b0, 3'd0, 4'b0000, 1'b0, 2'd0, 1'b1, 8'h00, 4'd8));  // R8 clears column 1 only
    step(mk(1'b0, 3'd0, 4'b0000, 1'b1, 2'd0, 1'b0, 8'h20, 4'd1));  // R1 column 0 was left set

    @(negedge clk);
    idle_inputs();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule